// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A tester clocks it through a mode-select line and a serial data line, and so steps a sixteen-state sequencer. The sequencer moves bits into and out of a 5-bit instruction register and one of three data registers: a single-bit pass-through register, a 32-bit identification register, and a chain of boundary cells. The length of the boundary chain is set by two parameters, one for input cells and one for output cells.

Input cells observe chip pins. Output cells sit between core outputs and pins. Only the external-test instruction hands the pins over to the boundary latches, through a test-mode output. With any other instruction the pins follow the core, so the block has no effect on system behaviour. A port-enable input must be high before the port can be used. While it is low, the sequencer is held in its reset state and the serial output driver is disabled.

Top module: `tapTop`

## Requirements
- R1: While portEnable is low the sequencer is held asynchronously in Test-Logic-Reset, dataOutEn is 0, testMode is 0 and pinOut equals coreOut. After release, the identification register is selected.
- R2: modeSel is sampled on rising edges of testClk and steps the standard sixteen-state diagram. Five consecutive rising edges with modeSel high reach Test-Logic-Reset from any state.
- R3: In Test-Logic-Reset the active instruction becomes the identification opcode 00001, and testMode drops at once.
- R4: In Capture-IR the instruction shift register loads 00001. Serial data enters at the most significant bit and the least significant bit leaves first, so the first five bits out of an instruction scan are 1,0,0,0,0.
- R5: The identification opcode 00001 selects a 32-bit register. Its capture value is ID_VALUE with bit 0 forced to 1, shifted out least significant bit first.
- R6: Opcode 11111 and every opcode other than 00000, 00001, 00010 and 00011 select the 1-bit pass-through register. That register captures 0 and delays dataIn by one shift.
- R7: Opcodes 00010 and 00011 select the boundary chain. Capture-DR loads pinIn into cells 0 to NUM_IN-1 and coreOut into cells NUM_IN and above, with cell 0 shifted out first. With either opcode, testMode stays 0 and pinOut follows coreOut.
- R8: Update-DR with the boundary chain selected copies shift cells NUM_IN and above into the output latches.
- R9: Opcode 00000 (external test) raises testMode and drives pinOut from the output latches.
- R10: dataOut changes only on falling edges of testClk. dataOutEn is 1 only while in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| testClk | input | 1 | Test clock |
| portEnable | input | 1 | Port enable; low holds the controller in reset |
| modeSel | input | 1 | Sequencer mode select, sampled on rising edges |
| dataIn | input | 1 | Serial data into the selected register |
| dataOut | output | 1 | Serial data out, updated on falling edges |
| dataOutEn | output | 1 | Output driver enable for dataOut |
| pinIn | input | NUM_IN | Values observed at input pins |
| coreOut | input | NUM_OUT | Core logic values bound for output pins |
| pinOut | output | NUM_OUT | Values driven to output pins |
| testMode | output | 1 | High when pins are driven from boundary latches |

## Verification
A vector table loads each opcode class in turn: identification, pass-through, two unassigned codes, and both sample codes with different pin and core patterns. Each vector then runs a data scan. The scan results show whether decoding picks the right register and whether the capture sources and cell order are correct. Directed scans then check the following:
- The one-bit delay of the pass-through register.
- Preloading the output latches, then handing them to the pins under external test.
- Leaving a half-finished shift with five high mode-select edges.
- Dropping the port enable in the middle of operation.
- Holding the serial output across a rising edge and changing it on the next falling edge.

// File: rtl/tapPkg.sv
package tapPkg;
  localparam int IR_W = 5;

  localparam logic [IR_W-1:0] OP_EXTEST  = 5'b00000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 5'b00001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 5'b00010;
  localparam logic [IR_W-1:0] OP_PRELOAD = 5'b00011;
  localparam logic [IR_W-1:0] OP_BYPASS  = 5'b11111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  typedef struct packed {
    logic inReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStrb_t;
endpackage

// File: rtl/tapFsm.sv
module tapFsm
  import tapPkg::*;
(
  input  logic     testClk,
  input  logic     portEnable,
  input  logic     modeSel,
  output tapStrb_t strb
);
  tapState_e state, nextState;

  always_comb begin
    case (state)
      ST_RESET:  nextState = modeSel ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = modeSel ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nextState = modeSel ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = modeSel ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nextState = modeSel ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nextState = modeSel ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = modeSel ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = modeSel ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nextState = modeSel ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nextState = modeSel ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nextState = modeSel ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nextState = modeSel ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nextState = modeSel ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = modeSel ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = modeSel ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nextState = modeSel ? ST_SEL_DR : ST_IDLE;
      default:   nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge testClk or negedge portEnable) begin
    if (!portEnable) state <= ST_RESET;
    else             state <= nextState;
  end

  always_comb begin
    strb.inReset   = (state == ST_RESET);
    strb.captureIr = (state == ST_CAP_IR);
    strb.shiftIr   = (state == ST_SH_IR);
    strb.updateIr  = (state == ST_UPD_IR);
    strb.captureDr = (state == ST_CAP_DR);
    strb.shiftDr   = (state == ST_SH_DR);
    strb.updateDr  = (state == ST_UPD_DR);
  end

  // checker bookkeeping: consecutive rising edges with modeSel high
  logic [2:0] onesCnt;
  always_ff @(posedge testClk or negedge portEnable) begin
    if (!portEnable)         onesCnt <= 3'd0;
    else if (!modeSel)       onesCnt <= 3'd0;
    else if (onesCnt != 3'd5) onesCnt <= onesCnt + 3'd1;
  end

  // R2
  five_ones_reset_chk: assert property (@(posedge testClk) disable iff (!portEnable)
    (onesCnt == 3'd5) |-> (state == ST_RESET));

  // R2
  reset_exit_chk: assert property (@(posedge testClk) disable iff (!portEnable)
    (state == ST_RESET && !modeSel) |=> (state == ST_IDLE));
endmodule

// File: rtl/tapDatapath.sv
module tapDatapath
  import tapPkg::*;
#(
  parameter int          NUM_IN   = 4,
  parameter int          NUM_OUT  = 4,
  parameter logic [31:0] ID_VALUE = 32'h4B2D_7035
) (
  input  logic               testClk,
  input  logic               portEnable,
  input  logic               dataIn,
  input  tapStrb_t           strb,
  input  logic [NUM_IN-1:0]  pinIn,
  input  logic [NUM_OUT-1:0] coreOut,
  output logic               dataOut,
  output logic               dataOutEn,
  output logic [NUM_OUT-1:0] pinOut,
  output logic               testMode
);
  localparam int BSR_LEN = NUM_IN + NUM_OUT;
  localparam int ID_W    = 32;

  logic [IR_W-1:0]    irShift, activeInstr, curInstr;
  logic               bypassBit;
  logic [ID_W-1:0]    idShift;
  logic [BSR_LEN-1:0] bsrShift, captureVec;
  logic [NUM_OUT-1:0] updLatch;
  logic               selId, selBsr, selBypass, serialBit;

  // decode; in reset the identification register is selected at once
  always_comb begin
    curInstr  = strb.inReset ? OP_IDCODE : activeInstr;
    selId     = (curInstr == OP_IDCODE);
    selBsr    = (curInstr == OP_EXTEST) || (curInstr == OP_SAMPLE) ||
                (curInstr == OP_PRELOAD);
    selBypass = !selId && !selBsr;
    testMode  = (curInstr == OP_EXTEST);
  end

  // boundary cell capture sources and pin drive
  for (genvar i = 0; i < NUM_IN; i++) begin : gInCell
    assign captureVec[i] = pinIn[i];
  end
  for (genvar j = 0; j < NUM_OUT; j++) begin : gOutCell
    assign captureVec[NUM_IN+j] = coreOut[j];
    assign pinOut[j] = testMode ? updLatch[j] : coreOut[j];
  end

  // instruction path
  always_ff @(posedge testClk or negedge portEnable) begin
    if (!portEnable) begin
      irShift     <= IR_CAPTURE;
      activeInstr <= OP_IDCODE;
    end else begin
      if (strb.captureIr)    irShift <= IR_CAPTURE;
      else if (strb.shiftIr) irShift <= {dataIn, irShift[IR_W-1:1]};
      if (strb.inReset)       activeInstr <= OP_IDCODE;
      else if (strb.updateIr) activeInstr <= irShift;
    end
  end

  // data registers
  always_ff @(posedge testClk or negedge portEnable) begin
    if (!portEnable) begin
      bypassBit <= 1'b0;
      idShift   <= '0;
      bsrShift  <= '0;
      updLatch  <= '0;
    end else begin
      if (strb.captureDr && selBypass)    bypassBit <= 1'b0;
      else if (strb.shiftDr && selBypass) bypassBit <= dataIn;

      if (strb.captureDr && selId)        idShift <= ID_VALUE | 32'd1;
      else if (strb.shiftDr && selId)     idShift <= {dataIn, idShift[ID_W-1:1]};

      if (strb.captureDr && selBsr)       bsrShift <= captureVec;
      else if (strb.shiftDr && selBsr)    bsrShift <= {dataIn, bsrShift[BSR_LEN-1:1]};

      if (strb.updateDr && selBsr)        updLatch <= bsrShift[BSR_LEN-1:NUM_IN];
    end
  end

  always_comb begin
    if (strb.shiftIr)  serialBit = irShift[0];
    else if (selId)    serialBit = idShift[0];
    else if (selBsr)   serialBit = bsrShift[0];
    else               serialBit = bypassBit;
  end

  // serial output retimed to the falling edge
  always_ff @(negedge testClk or negedge portEnable) begin
    if (!portEnable) begin
      dataOut   <= 1'b1;
      dataOutEn <= 1'b0;
    end else begin
      dataOut   <= serialBit;
      dataOutEn <= strb.shiftIr || strb.shiftDr;
    end
  end

  // R3
  instr_change_chk: assert property (@(posedge testClk) disable iff (!portEnable)
    !$stable(activeInstr) |-> $past(strb.updateIr || strb.inReset));

  // R4
  ir_capture_chk: assert property (@(posedge testClk) disable iff (!portEnable)
    strb.captureIr |=> (irShift == IR_CAPTURE));

  // R5
  id_lsb_chk: assert property (@(posedge testClk) disable iff (!portEnable)
    (strb.captureDr && selId) |=> idShift[0]);

  // R6
  bypass_capture_chk: assert property (@(posedge testClk) disable iff (!portEnable)
    (strb.captureDr && selBypass) |=> !bypassBit);

  // R10
  out_enable_chk: assert property (@(posedge testClk) disable iff (!portEnable)
    dataOutEn |-> (strb.shiftIr || strb.shiftDr));

  // R8
  latch_hold_chk: assert property (@(posedge testClk) disable iff (!portEnable)
    !$stable(updLatch) |-> $past(strb.updateDr));
endmodule

// File: rtl/tapTop.sv
module tapTop
  import tapPkg::*;
#(
  parameter int          NUM_IN   = 4,
  parameter int          NUM_OUT  = 4,
  parameter logic [31:0] ID_VALUE = 32'h4B2D_7035
) (
  input  logic               testClk,
  input  logic               portEnable,
  input  logic               modeSel,
  input  logic               dataIn,
  output logic               dataOut,
  output logic               dataOutEn,
  input  logic [NUM_IN-1:0]  pinIn,
  input  logic [NUM_OUT-1:0] coreOut,
  output logic [NUM_OUT-1:0] pinOut,
  output logic               testMode
);
  tapStrb_t strb;

  tapFsm uFsm (
    .testClk    (testClk),
    .portEnable (portEnable),
    .modeSel    (modeSel),
    .strb       (strb)
  );

  tapDatapath #(
    .NUM_IN   (NUM_IN),
    .NUM_OUT  (NUM_OUT),
    .ID_VALUE (ID_VALUE)
  ) uPath (
    .testClk    (testClk),
    .portEnable (portEnable),
    .dataIn     (dataIn),
    .strb       (strb),
    .pinIn      (pinIn),
    .coreOut    (coreOut),
    .dataOut    (dataOut),
    .dataOutEn  (dataOutEn),
    .pinOut     (pinOut),
    .testMode   (testMode)
  );
endmodule

// File: tb/tb_tapTop.sv
`timescale 1ns/1ps
module tb_tapTop;
  localparam logic [31:0] ID_RAW = 32'h4B2D_7034;
  localparam logic [31:0] ID_EXP = ID_RAW | 32'd1;

  typedef struct packed {
    logic [4:0]  op;
    logic [5:0]  len;
    logic [3:0]  pins;
    logic [3:0]  core;
    logic [31:0] exp;
  } vec_t;

  // R5 identification, R6 pass-through and unassigned, R7 sample codes
  localparam vec_t VECS [6] = '{
    '{5'b00001, 6'd32, 4'h0, 4'h0, ID_EXP},
    '{5'b11111, 6'd1,  4'hF, 4'hF, 32'd0},
    '{5'b01010, 6'd1,  4'h3, 4'h1, 32'd0},
    '{5'b00010, 6'd8,  4'h5, 4'hC, 32'h0000_00C5},
    '{5'b00011, 6'd8,  4'h9, 4'h3, 32'h0000_0039},
    '{5'b10000, 6'd1,  4'h6, 4'h6, 32'd0}
  };

  logic clk = 1'b0;
  logic portEnable, tms, tdi;
  logic [3:0] pinIn, coreOut, pinOut;
  logic dataOut, dataOutEn, testMode;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tapTop #(.NUM_IN(4), .NUM_OUT(4), .ID_VALUE(ID_RAW)) dut (
    .testClk(clk), .portEnable(portEnable), .modeSel(tms), .dataIn(tdi),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .pinIn(pinIn), .coreOut(coreOut),
    .pinOut(pinOut), .testMode(testMode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o, output logic oe);
    @(negedge clk); #1; tms = m; tdi = d; #2;
    o = dataOut; oe = dataOutEn;
    @(posedge clk);
  endtask

  task automatic goIdle();
    logic o, oe;
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o, oe);
    tick(1'b0, 1'b0, o, oe);
  endtask

  task automatic loadIr(input logic [4:0] op, output logic [4:0] cap);
    logic o, oe;
    tick(1'b1, 1'b0, o, oe);
    tick(1'b1, 1'b0, o, oe);
    tick(1'b0, 1'b0, o, oe);
    tick(1'b0, 1'b0, o, oe);
    for (int i = 0; i < 5; i++) begin
      tick(i == 4, op[i], o, oe);
      cap[i] = o;
    end
    tick(1'b1, 1'b0, o, oe);
    tick(1'b0, 1'b0, o, oe);
  endtask

  task automatic scanDr(input logic [31:0] din, input int len,
                        output logic [31:0] dout, output logic enAll);
    logic o, oe;
    dout = '0; enAll = 1'b1;
    tick(1'b1, 1'b0, o, oe);
    tick(1'b0, 1'b0, o, oe);
    tick(1'b0, 1'b0, o, oe);
    for (int i = 0; i < len; i++) begin
      tick(i == len - 1, din[i], o, oe);
      dout[i] = o;
      enAll = enAll & oe;
    end
    tick(1'b1, 1'b0, o, oe);
    tick(1'b0, 1'b0, o, oe);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [4:0] cap;
    logic [31:0] dout;
    logic en, o, oe;
    portEnable = 1'b0; tms = 1'b1; tdi = 1'b0; pinIn = 4'h0; coreOut = 4'hA;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 dataOutEn in reset", {31'd0, dataOutEn}, 32'd0);
    check("R1 testMode in reset", {31'd0, testMode}, 32'd0);
    check("R1 pinOut follows core", {28'd0, pinOut}, 32'hA);
    @(negedge clk); portEnable = 1'b1;
    goIdle();

    // R3 identification selected after reset, no instruction load
    scanDr(32'd0, 32, dout, en);
    check("R3 default id scan", dout, ID_EXP);

    for (int v = 0; v < 6; v++) begin
      pinIn = VECS[v].pins; coreOut = VECS[v].core;
      loadIr(VECS[v].op, cap);
      check("R4 ir capture", {27'd0, cap}, 32'h1);
      scanDr(32'd0, int'(VECS[v].len), dout, en);
      check("R5/R6/R7 table scan", dout, VECS[v].exp);
      check("R10 enable during shift", {31'd0, en}, 32'd1);
      check("R7 testMode low", {31'd0, testMode}, 32'd0);
      check("R7 pinOut follows core", {28'd0, pinOut}, {28'd0, coreOut});
    end

    // R6 one-bit delay through pass-through register
    loadIr(5'b11111, cap);
    scanDr(32'h0000_00B2, 8, dout, en);
    check("R6 bypass delay", dout, 32'h0000_0064);

    // R8 preload latches; R7 pins unaffected
    coreOut = 4'hA; pinIn = 4'h7;
    loadIr(5'b00011, cap);
    scanDr(32'h0000_0050, 8, dout, en);
    #1;
    check("R7 preload no effect", {28'd0, pinOut}, 32'hA);
    // R9 external test drives latches
    loadIr(5'b00000, cap);
    #1;
    check("R9 testMode high", {31'd0, testMode}, 32'd1);
    check("R9 pinOut from latch", {28'd0, pinOut}, 32'h5);
    scanDr(32'h0000_0030, 8, dout, en);
    #1;
    check("R7 extest capture", dout, 32'h0000_00A7);
    check("R8 update latch", {28'd0, pinOut}, 32'h3);

    // R2 five high edges from the middle of a shift
    tick(1'b1, 1'b0, o, oe);
    tick(1'b0, 1'b0, o, oe);
    tick(1'b0, 1'b0, o, oe);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, o, oe);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o, oe);
    #1;
    check("R2 enable off after escape", {31'd0, oe}, 32'd0);
    check("R3 testMode drops in reset", {31'd0, testMode}, 32'd0);
    check("R3 pinOut follows core", {28'd0, pinOut}, 32'hA);
    tick(1'b0, 1'b0, o, oe);
    scanDr(32'd0, 32, dout, en);
    check("R2 id after escape", dout, ID_EXP);

    // R1 port disable mid-operation
    loadIr(5'b00000, cap);
    @(negedge clk); portEnable = 1'b0;
    #2;
    check("R1 testMode on disable", {31'd0, testMode}, 32'd0);
    check("R1 enable on disable", {31'd0, dataOutEn}, 32'd0);
    @(negedge clk); portEnable = 1'b1;
    tick(1'b0, 1'b0, o, oe);
    scanDr(32'd0, 32, dout, en);
    check("R1 id after disable", dout, ID_EXP);

    // R10 output changes on falling edge only (id bit0=1, bit1=0)
    tick(1'b1, 1'b0, o, oe);
    tick(1'b0, 1'b0, o, oe);
    tick(1'b0, 1'b0, o, oe);
    @(negedge clk); #1; tms = 1'b0; #2;
    check("R10 first bit", {31'd0, dataOut}, 32'd1);
    @(posedge clk); #1;
    check("R10 held after rise", {31'd0, dataOut}, 32'd1);
    @(negedge clk); #1;
    check("R10 next bit after fall", {31'd0, dataOut}, 32'd0);
    goIdle();

    finishRun();
  end
endmodule